// File: doc/BRIEF.md
# I2C Channel-Select Slave Controller

This block is an I2C slave that owns one small control register. The register decides which of four downstream bus segments an external switch fabric connects to the main bus. SCL and SDA are sampled by a system clock through a two-flop synchronizer. The block finds START and STOP conditions and matches a 7-bit address, part of it fixed and part of it taken from strap pins. It acknowledges a match, stores written bytes and returns the register on reads. SDA is driven through an open-drain style low-enable output.

A build-time parameter picks one of two modes. In switch mode any combination of the four channels may be on. In multiplexer mode at most one channel is on, and it is picked by an enable bit and a 2-bit index. A written value reaches the channel-enable outputs only when the STOP condition arrives, so a transaction can change its mind before it ends.

Top module: `i2c_chan_sel`

## Requirements
- R1: In switch mode (MUX_MODE=0) the address matches when its seven bits, sent MSB first, equal binary 11100 followed by addr_pins[1:0]; addr_pins[2] has no effect. On a match the slave pulls SDA low through the whole 9th SCL clock.
- R2: In multiplexer mode (MUX_MODE=1) the address matches when it equals binary 1110 followed by addr_pins[2:0]. Acknowledge timing is the same as in R1.
- R3: A non-matching address gets no acknowledge. The slave then ignores the bus until the next START, and its register and enables stay unchanged.
- R4: In a write (R/W bit 0), the slave acknowledges each data byte and stores the byte's low four bits in the register. When several bytes arrive in one transaction, only the last one remains.
- R5: The channel enables change only in response to a STOP condition. They then take the decoded value of the register. Bytes received before the STOP leave the enables untouched.
- R6: In switch mode, register bit k enables channel k (k = 0..3), and every combination is allowed.
- R7: In multiplexer mode, register bit 2 = 0 turns all channels off. Bit 2 = 1 turns on exactly the channel given by bits 1..0, and bit 3 is ignored.
- R8: A read (R/W bit 1) returns one byte, MSB first: 0000 followed by the four register bits. SDA is then released whatever the master answers, and the register and enables are not altered.
- R9: A START, including a repeated START in the middle of a byte, restarts address reception. Any partial byte is discarded.
- R10: A STOP in the middle of a data byte ends the transfer without storing the partial byte. The enables take the last completely received value.
- R11: Synchronous active-high rst clears the register and the enables, releases SDA and returns the protocol engine to idle.
- R12: The slave changes its SDA drive only after it has seen a falling SCL edge, so the data it drives is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_pins | input | 3 | Strap pins for the low address bits (bit 2 is used only in multiplexer mode) |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_low | output | 1 | When 1, the data line is pulled low (open-drain drive) |
| chan_en | output | 4 | Per-channel enables for the external switch fabric |

## Verification
The embedded assertions check four things on every clock:
- the enables move only right after a detected STOP;
- the register moves only right after a rising SCL edge;
- the SDA drive rises only after a falling SCL edge;
- in multiplexer mode at most one channel is on.

Reset clearing is also asserted. Only the bench scenarios can show the rest: address matching and rejection, the last-byte rule, the delay of the enables until STOP, the read value, and recovery from a repeated START or an aborted byte. The bench shows these by driving real bus waveforms against a switch-mode and a multiplexer-mode instance that share one bus.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    localparam int NUM_CH     = 4;
    localparam int CTRL_W     = 4;
    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);

    localparam logic [4:0] SW_FIXED  = 5'b11100;
    localparam logic [3:0] MUX_FIXED = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_HOLD,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } fsm_state_t;

    // bus events derived from the synchronized lines
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // address byte: [7:1] address MSB first, [0] read/write
    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [2:0] pins,
                                      input bit mux);
        if (mux)
            return (b[7:4] == MUX_FIXED) && (b[3:1] == pins);
        else
            return (b[7:3] == SW_FIXED) && (b[2:1] == pins[1:0]);
    endfunction

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '1;
                    else     stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '1;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/chsel_events.sv
module chsel_events
    import chsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.sda      = sda;
        evt.scl_rise = scl & ~scl_q;
        evt.scl_fall = ~scl & scl_q;
        evt.start    = scl & scl_q & sda_q & ~sda;
        evt.stop     = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/chsel_fsm.sv
module chsel_fsm
    import chsel_pkg::*;
#(
    parameter bit MUX_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [2:0]        addr_pins,
    output logic              sda_low,
    output logic [CTRL_W-1:0] ctrl
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    fsm_state_t           state;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-2:0]    shreg;
    logic [BYTE_W-2:0]    tx;
    logic                 rw;
    logic [BYTE_W-1:0]    rd_byte;
    logic [BYTE_W-1:0]    rx_byte;

    assign rd_byte = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
    assign rx_byte = {shreg, evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            sda_low <= 1'b0;
            ctrl    <= '0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
        end else if (evt.stop) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: if (evt.scl_rise) begin
                    shreg <= rx_byte[BYTE_W-2:0];
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        if (addr_hit(rx_byte, addr_pins, MUX_MODE)) begin
                            state <= ST_ACK_WAIT;
                            rw    <= evt.sda;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK_WAIT: if (evt.scl_fall) begin
                    sda_low <= 1'b1;
                    state   <= ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (evt.scl_fall) begin
                    cnt <= '0;
                    if (rw) begin
                        tx      <= rd_byte[BYTE_W-2:0];
                        sda_low <= ~rd_byte[BYTE_W-1];
                        state   <= ST_RDATA;
                    end else begin
                        sda_low <= 1'b0;
                        state   <= ST_WDATA;
                    end
                end
                ST_WDATA: if (evt.scl_rise) begin
                    shreg <= rx_byte[BYTE_W-2:0];
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        ctrl  <= rx_byte[CTRL_W-1:0];
                        state <= ST_ACK_WAIT;
                    end
                end
                ST_RDATA: if (evt.scl_fall) begin
                    if (cnt == LAST_BIT) begin
                        sda_low <= 1'b0;
                        state   <= ST_IGNORE;
                    end else begin
                        sda_low <= ~tx[BYTE_W-2];
                        tx      <= {tx[BYTE_W-3:0], 1'b0};
                        cnt     <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R4
    ctrl_on_rise_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        !$stable(ctrl) |-> $past(evt.scl_rise));

    // R12
    sda_after_fall_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(sda_low) |-> $past(evt.scl_fall));
endmodule

// File: rtl/chsel_decode.sv
module chsel_decode
    import chsel_pkg::*;
#(
    parameter bit MUX_MODE = 1'b0
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic [NUM_CH-1:0] sel
);
    generate
        if (MUX_MODE) begin : g_mux
            always_comb begin
                sel = '0;
                if (ctrl[2]) sel[ctrl[1:0]] = 1'b1;
            end
        end else begin : g_switch
            assign sel = ctrl[NUM_CH-1:0];
        end
    endgenerate
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
    import chsel_pkg::*;
#(
    parameter bit MUX_MODE    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr_pins,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_low,
    output logic [3:0] chan_en
);
    logic [1:0]        lines;
    bus_evt_t          evt;
    logic [CTRL_W-1:0] ctrl;
    logic [NUM_CH-1:0] sel;

    chsel_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst), .din({scl_in, sda_in}), .dout(lines)
    );

    chsel_events u_events (
        .clk(clk), .rst(rst), .scl(lines[1]), .sda(lines[0]), .evt(evt)
    );

    chsel_fsm #(.MUX_MODE(MUX_MODE)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .addr_pins(addr_pins),
        .sda_low(sda_low), .ctrl(ctrl)
    );

    chsel_decode #(.MUX_MODE(MUX_MODE)) u_decode (
        .ctrl(ctrl), .sel(sel)
    );

    always_ff @(posedge clk) begin
        if (rst)           chan_en <= '0;
        else if (evt.stop) chan_en <= sel;
    end

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R5
    commit_at_stop_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        !$stable(chan_en) |-> $past(evt.stop));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (chan_en == '0) && !sda_low);

    generate
        if (MUX_MODE) begin : g_mux_chk
            // R7
            mux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(chan_en));
        end
    endgenerate
endmodule

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;
    localparam int HP = 6;
    localparam logic [6:0] SW_ADDR = 7'b1110001; // switch pins 101, bit2 ignored
    localparam logic [6:0] MX_ADDR = 7'b1110110; // mux pins 110

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sw_low, mx_low, sda;
    logic [3:0] sw_en, mx_en;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda = m_sda & ~sw_low & ~mx_low;

    i2c_chan_sel #(.MUX_MODE(1'b0)) u_i2c_chan_sel (
        .clk(clk), .rst(rst), .addr_pins(3'b101), .scl_in(m_scl), .sda_in(sda),
        .sda_low(sw_low), .chan_en(sw_en));

    i2c_chan_sel #(.MUX_MODE(1'b1)) u_i2c_chan_sel_mux (
        .clk(clk), .rst(rst), .addr_pins(3'b110), .scl_in(m_scl), .sda_in(sda),
        .sda_low(mx_low), .chan_en(mx_en));

    function automatic logic [3:0] exp_sw(input logic [7:0] b);
        return b[3:0];
    endfunction

    function automatic logic [3:0] exp_mx(input logic [7:0] b);
        return b[2] ? (4'b0001 << b[1:0]) : 4'b0000;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(2); m_sda = 1'b1; tick(HP); m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2); m_sda = 1'b0; tick(HP); m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP + 4);
    endtask

    task automatic send_bit(input logic b);
        tick(2); m_sda = b; tick(HP); m_scl = 1'b1; tick(HP); m_scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        tick(2); m_sda = 1'b1; tick(HP); m_scl = 1'b1; tick(HP/2);
        b = sda; tick(HP/2); m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(1'b1); // master NACK
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rv;
        logic [3:0] sw_ctrl, mx_ctrl;
        void'($urandom(32'd2024));
        sw_ctrl = 4'h0; mx_ctrl = 4'h0;
        tick(5); rst = 1'b0; tick(5);

        // R11 reset state
        check("R11 reset sw_en", {4'h0, sw_en}, 8'h00);
        check("R11 reset mx_en", {4'h0, mx_en}, 8'h00);
        check("R11 reset sda", {7'h0, sda}, 8'h01);

        // R1 R4 R5 R6: switch write, enables held until STOP
        bus_start();
        put_byte({SW_ADDR, 1'b0}, ack);
        check("R1 switch address ack", {7'h0, ack}, 8'h01);
        put_byte(8'hA3, ack);
        check("R4 data ack", {7'h0, ack}, 8'h01);
        put_byte(8'h5A, ack);
        check("R5 enables before stop", {4'h0, sw_en}, 8'h00);
        bus_stop();
        check("R4 R6 last byte 0x5A", {4'h0, sw_en}, {4'h0, exp_sw(8'h5A)});
        check("R3 mux untouched by switch write", {4'h0, mx_en}, 8'h00);
        sw_ctrl = 4'hA;

        // R2 R7: mux decodes
        bus_start();
        put_byte({MX_ADDR, 1'b0}, ack);
        check("R2 mux address ack", {7'h0, ack}, 8'h01);
        put_byte(8'h05, ack);
        bus_stop();
        check("R7 mux 0x05", {4'h0, mx_en}, {4'h0, exp_mx(8'h05)});
        bus_start(); put_byte({MX_ADDR, 1'b0}, ack); put_byte(8'h03, ack); bus_stop();
        check("R7 mux enable bit clear", {4'h0, mx_en}, 8'h00);
        bus_start(); put_byte({MX_ADDR, 1'b0}, ack); put_byte(8'h0F, ack); bus_stop();
        check("R7 mux bit3 ignored", {4'h0, mx_en}, 8'h08);
        mx_ctrl = 4'hF;

        // R8 read returns register, no change
        bus_start();
        put_byte({MX_ADDR, 1'b1}, ack);
        check("R8 read address ack", {7'h0, ack}, 8'h01);
        get_byte(rv);
        check("R8 read value", rv, {4'h0, mx_ctrl});
        tick(HP);
        check("R8 sda released after read", {7'h0, sda}, 8'h01);
        bus_stop();
        check("R8 enables unchanged by read", {4'h0, mx_en}, 8'h08);
        bus_start(); put_byte({SW_ADDR, 1'b1}, ack); get_byte(rv); bus_stop();
        check("R8 switch read value", rv, {4'h0, sw_ctrl});
        check("R8 switch enables unchanged", {4'h0, sw_en}, {4'h0, sw_ctrl});

        // R3 wrong addresses
        bus_start(); put_byte({7'b1110011, 1'b0}, ack);
        check("R3 no ack for foreign address", {7'h0, ack}, 8'h00);
        put_byte(8'h01, ack); bus_stop();
        check("R3 switch unchanged", {4'h0, sw_en}, {4'h0, sw_ctrl});
        check("R3 mux unchanged", {4'h0, mx_en}, 8'h08);
        bus_start(); put_byte({7'b1111001, 1'b0}, ack);
        check("R1 fixed bits must match", {7'h0, ack}, 8'h00);
        bus_stop();

        // R10 stop mid-byte
        bus_start(); put_byte({SW_ADDR, 1'b0}, ack); put_byte(8'h06, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check("R10 partial byte dropped", {4'h0, sw_en}, 8'h06);
        sw_ctrl = 4'h6;

        // R9 repeated start mid-byte
        bus_start(); put_byte({SW_ADDR, 1'b0}, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start(); put_byte({SW_ADDR, 1'b0}, ack);
        check("R9 ack after repeated start", {7'h0, ack}, 8'h01);
        put_byte(8'h09, ack); bus_stop();
        check("R9 value after repeated start", {4'h0, sw_en}, 8'h09);
        sw_ctrl = 4'h9;

        // R6 R7 random writes
        for (int it = 0; it < 30; it++) begin
            bit tgt_mux;
            int n;
            logic [7:0] b;
            tgt_mux = $urandom_range(0, 1) == 1;
            n = $urandom_range(1, 3);
            bus_start();
            put_byte({tgt_mux ? MX_ADDR : SW_ADDR, 1'b0}, ack);
            for (int k = 0; k < n; k++) begin
                b = 8'($urandom);
                put_byte(b, ack);
            end
            bus_stop();
            if (tgt_mux) mx_ctrl = b[3:0]; else sw_ctrl = b[3:0];
            check("R6 random switch", {4'h0, sw_en}, {4'h0, exp_sw({4'h0, sw_ctrl})});
            check("R7 random mux", {4'h0, mx_en}, {4'h0, exp_mx({4'h0, mx_ctrl})});
        end

        // R11 reset mid-transaction
        bus_start(); put_byte({SW_ADDR, 1'b0}, ack);
        tick(2); rst = 1'b1; tick(3); rst = 1'b0; tick(3);
        check("R11 reset clears switch", {4'h0, sw_en}, 8'h00);
        check("R11 reset clears mux", {4'h0, mx_en}, 8'h00);
        m_scl = 1'b1; m_sda = 1'b1; tick(HP);
        bus_start(); put_byte({SW_ADDR, 1'b1}, ack); get_byte(rv); bus_stop();
        check("R11 register cleared", rv, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule